// File: doc/BRIEF.md
# Byte-Lane Parity Checker and Generator

This block holds the parity logic of one 36-bit data port. The port carries four 9-bit lanes, and the top bit of each lane is that lane's parity bit. On data that arrives at the port pins, the block checks every lane against the selected parity sense. It drives an active-low error flag when any lane fails. On data that leaves the port during a read, it can overwrite each lane's top bit with a freshly computed parity bit. A per-port generate enable turns this on.

One bank of lane parity trees does two jobs. It checks the pins, and it also generates parity for mailbox reads. While a generating mailbox read is set up, the trees are busy with the outgoing word, so the error flag is held inactive. Reads from the queue path that use generation have a small generator of their own, so checking continues during those reads. The whole block is combinational. It has no clock and no state, and it sits between the port pins and the storage paths.

Top module: `lane_parity_unit`

## Requirements
- R1: The 36-bit word is split into lanes at bits [8:0], [17:9], [26:18] and [35:27]. Bit 8 of each lane (bits 8, 17, 26, 35) is its parity bit, and the other eight bits are its payload.
- R2: `par_odd`=1 selects odd parity, where a lane passes when its nine bits hold an odd number of ones. `par_odd`=0 selects even parity, where a lane passes when its nine bits hold an even number of ones. This sense applies to both checking and generation.
- R3: When not forced (see R6), `par_err_n` is 1 when every lane of `pin_data` passes. It is 0 when one or more lanes fail, and a single failing lane in any position is enough.
- R4: With `gen_en`=1, each lane of `out_data` keeps its eight payload bits from `rd_data`. Its bit 8 is replaced by the parity bit that makes the lane pass under the selected sense.
- R5: With `gen_en`=0, `out_data` equals `rd_data` exactly, parity bits included.
- R6: With `wr_sel`=0 (read), `mbox_sel`=1 and `gen_en`=1, `par_err_n` is 1 whatever is on `pin_data`.
- R7: The forcing of R6 happens only under that exact combination. A generating queue read (`mbox_sel`=0), a write (`wr_sel`=1), or a read without generation still reports pin parity errors.
- R8: Both outputs are purely combinational from the inputs and settle within the same cycle as an input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| par_odd | input | 1 | Parity sense: 1 odd, 0 even |
| gen_en | input | 1 | Parity generation enable for read data |
| wr_sel | input | 1 | Port direction: 1 write, 0 read |
| mbox_sel | input | 1 | Mailbox path selected for this access |
| pin_data | input | 36 | Word present on the port pins, checked for parity |
| rd_data | input | 36 | Word read from storage or mailbox, about to leave the port |
| out_data | output | 36 | Read word after optional parity generation |
| par_err_n | output | 1 | Active-low parity error flag |

## Verification
Every result of this block is due in the same cycle as its stimulus, with no register between an input and an output. The bench therefore drives a new vector on the falling clock edge and samples both outputs a few nanoseconds later, well before the next rising edge. Random vectors mix correct lanes with single and multiple corrupted lanes. Directed vectors cover the exact forcing combination and its three near neighbours, so the forcing is shown to be both present and narrow.

// File: rtl/lane_parity_pkg.sv
// Package: shared types and helpers for the lane parity unit.
// Assumes lanes are equal width with the parity bit in the top position.
package lane_parity_pkg;

    // Parity sense selected by the port's odd/even control
    typedef enum logic {
        PAR_EVEN = 1'b0,
        PAR_ODD  = 1'b1
    } par_sense_e;

    // Lowest bit index of a lane inside the packed word
    function automatic int unsigned lane_base(input int unsigned lane, input int unsigned lane_w);
        return lane * lane_w;
    endfunction

endpackage

// File: rtl/par_tree.sv
// Module: par_tree
// An XOR reduction over W inputs, inverted when odd parity is selected.
// Fed a full lane, it returns 1 on a failing lane. Fed only the payload
// (with a zero in the parity slot), it returns the parity bit to emit.
// Assumes W >= 2. Purely combinational.
module par_tree #(
    parameter int W = 9
) (
    input  logic [W-1:0] bits,
    input  logic         odd,
    output logic         flip
);
    // Reduce and apply the parity sense
    always_comb begin
        flip = (^bits) ^ odd;
    end
endmodule

// File: rtl/par_err_merge.sv
// Module: par_err_merge
// Folds the per-lane failure bits into one active-low error flag.
// A force input holds the flag inactive while the trees serve generation.
// Purely combinational.
module par_err_merge #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] lane_fail,
    input  logic             force_ok,
    output logic             err_n
);
    // Any failing lane pulls the flag low unless forced inactive
    always_comb begin
        err_n = force_ok | ~(|lane_fail);
    end
endmodule

// File: rtl/lane_parity_unit.sv
// Module: lane_parity_unit (top)
// Parity check on incoming pin data and optional parity generation on
// outgoing read data for one port of LANES lanes of LANE_W bits.
// One bank of trees checks the pins and also generates parity for
// mailbox reads. A smaller payload-only bank generates for queue reads.
// Assumes: the parity bit is the top bit of each lane; no clock, no state.
module lane_parity_unit
    import lane_parity_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      par_odd,
    input  logic                      gen_en,
    input  logic                      wr_sel,
    input  logic                      mbox_sel,
    input  logic [LANES*LANE_W-1:0]   pin_data,
    input  logic [LANES*LANE_W-1:0]   rd_data,
    output logic [LANES*LANE_W-1:0]   out_data,
    output logic                      par_err_n
);
    localparam int DW    = LANES * LANE_W;
    localparam int PAY_W = LANE_W - 1;

    par_sense_e        sense;
    logic              odd_sel;
    logic              share_gen;   // trees are lent to mailbox generation
    logic [LANES-1:0]  shared_flip; // fail bit or generated mailbox bit
    logic [LANES-1:0]  queue_gen;   // generated bit for queue reads
    logic [LANES-1:0]  lane_fail;

    // Decode the parity sense into a single tree control
    always_comb begin
        sense   = par_sense_e'(par_odd);
        odd_sel = (sense == PAR_ODD);
    end

    // A generating mailbox read takes over the shared trees
    always_comb begin
        share_gen = ~wr_sel & mbox_sel & gen_en;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int BASE = g * LANE_W;
        logic [LANE_W-1:0] tree_in;

        // Steer pins or the outgoing mailbox payload into the shared tree
        always_comb begin
            if (share_gen) begin
                tree_in = {1'b0, rd_data[BASE +: PAY_W]};
            end else begin
                tree_in = pin_data[BASE +: LANE_W];
            end
        end

        par_tree #(.W(LANE_W)) u_shared (
            .bits (tree_in),
            .odd  (odd_sel),
            .flip (shared_flip[g])
        );

        par_tree #(.W(PAY_W)) u_queue_gen (
            .bits (rd_data[BASE +: PAY_W]),
            .odd  (odd_sel),
            .flip (queue_gen[g])
        );

        // Failure bits are only meaningful while the tree checks the pins
        always_comb begin
            lane_fail[g] = shared_flip[g] & ~share_gen;
        end

        // Rebuild the outgoing lane, replacing its parity bit when enabled
        always_comb begin
            out_data[BASE +: PAY_W] = rd_data[BASE +: PAY_W];
            if (!gen_en) begin
                out_data[BASE + PAY_W] = rd_data[BASE + PAY_W];
            end else if (share_gen) begin
                out_data[BASE + PAY_W] = shared_flip[g];
            end else begin
                out_data[BASE + PAY_W] = queue_gen[g];
            end
        end
    end

    par_err_merge #(.LANES(LANES)) u_merge (
        .lane_fail (lane_fail),
        .force_ok  (share_gen),
        .err_n     (par_err_n)
    );

    // Keep DW referenced for width documentation of the packed word
    initial begin
        if (DW != LANES * LANE_W) $display("lane_parity_unit: width mismatch");
    end
endmodule

// File: rtl/lane_parity_unit_chk.sv
// Module: lane_parity_unit_chk
// Assertion checker bound to lane_parity_unit. The block has no clock, so
// every check is an immediate assertion evaluated on settled values.
// Checks run only when all inputs are known.
module lane_parity_unit_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input logic                    par_odd,
    input logic                    gen_en,
    input logic                    wr_sel,
    input logic                    mbox_sel,
    input logic [LANES*LANE_W-1:0] pin_data,
    input logic [LANES*LANE_W-1:0] rd_data,
    input logic [LANES*LANE_W-1:0] out_data,
    input logic                    par_err_n
);
    localparam int PAY_W = LANE_W - 1;

    logic known;
    logic forced;
    logic any_bad;

    // Gate checks on fully known inputs and derive the forcing condition
    always_comb begin
        known  = !$isunknown({par_odd, gen_en, wr_sel, mbox_sel, pin_data, rd_data});
        forced = !wr_sel && mbox_sel && gen_en;
        any_bad = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if ((^pin_data[i*LANE_W +: LANE_W]) != par_odd) any_bad = 1'b1;
        end
    end

    // R6: forced inactive during a generating mailbox read
    always_comb begin
        if (known && forced) begin
            assert_force_inactive_R6: assert (par_err_n == 1'b1);
        end
    end

    // R3 / R7: outside the forcing case the flag follows the pin lanes
    always_comb begin
        if (known && !forced) begin
            assert_flag_tracks_pins_R3: assert (par_err_n == !any_bad);
        end
    end

    // R5: pass-through when generation is disabled
    always_comb begin
        if (known && !gen_en) begin
            assert_pass_through_R5: assert (out_data == rd_data);
        end
    end

    // R4: generated lanes keep payload and satisfy the selected sense
    always_comb begin
        if (known && gen_en) begin
            for (int i = 0; i < LANES; i++) begin
                assert_payload_kept_R4: assert (out_data[i*LANE_W +: PAY_W] == rd_data[i*LANE_W +: PAY_W]);
                assert_lane_passes_R4: assert ((^out_data[i*LANE_W +: LANE_W]) == par_odd);
            end
        end
    end
endmodule

bind lane_parity_unit lane_parity_unit_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .par_odd   (par_odd),
    .gen_en    (gen_en),
    .wr_sel    (wr_sel),
    .mbox_sel  (mbox_sel),
    .pin_data  (pin_data),
    .rd_data   (rd_data),
    .out_data  (out_data),
    .par_err_n (par_err_n)
);

// File: tb/lane_parity_unit_test.sv
// Bench for lane_parity_unit: directed corners plus seeded random vectors.
// Inputs change on the falling edge; outputs are sampled 3 ns later.
module lane_parity_unit_test;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DW     = LANES * LANE_W;

    logic          clk = 1'b0;
    logic          par_odd = 1'b0, gen_en = 1'b0, wr_sel = 1'b0, mbox_sel = 1'b0;
    logic [DW-1:0] pin_data = '0, rd_data = '0;
    logic [DW-1:0] out_data;
    logic          par_err_n;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    lane_parity_unit #(.LANES(LANES), .LANE_W(LANE_W)) uut (
        .par_odd (par_odd), .gen_en (gen_en), .wr_sel (wr_sel), .mbox_sel (mbox_sel),
        .pin_data (pin_data), .rd_data (rd_data),
        .out_data (out_data), .par_err_n (par_err_n)
    );

    // Expected flag from R2, R3, R6 and R7
    function automatic logic exp_err_n(logic odd, logic gen, logic wr, logic mb, logic [DW-1:0] pins);
        if (!wr && mb && gen) return 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if ($countones(pins[i*LANE_W +: LANE_W]) % 2 != int'(odd)) return 1'b0;
        end
        return 1'b1;
    endfunction

    // Expected outgoing word from R1, R4 and R5
    function automatic logic [DW-1:0] exp_out(logic odd, logic gen, logic [DW-1:0] rd);
        logic [DW-1:0] r = rd;
        if (gen) begin
            for (int i = 0; i < LANES; i++) begin
                logic ones_odd = ($countones(rd[i*LANE_W +: 8]) % 2) == 1;
                r[i*LANE_W + 8] = (odd ? !ones_odd : ones_odd);
            end
        end
        return r;
    endfunction

    // Make every lane pass under the given sense
    function automatic logic [DW-1:0] fix_lanes(logic odd, logic [DW-1:0] w);
        logic [DW-1:0] r = w;
        for (int i = 0; i < LANES; i++) begin
            r[i*LANE_W + 8] = 1'b0;
            if ($countones(r[i*LANE_W +: LANE_W]) % 2 != int'(odd)) r[i*LANE_W + 8] = 1'b1;
        end
        return r;
    endfunction

    task automatic apply(logic odd, logic gen, logic wr, logic mb, logic [DW-1:0] pins,
                         logic [DW-1:0] rd, string tag);
        logic          e_err;
        logic [DW-1:0] e_out;
        @(negedge clk);
        par_odd = odd; gen_en = gen; wr_sel = wr; mbox_sel = mb;
        pin_data = pins; rd_data = rd;
        #3;
        e_err = exp_err_n(odd, gen, wr, mb, pins);
        e_out = exp_out(odd, gen, rd);
        vectors++;
        if (par_err_n !== e_err) begin
            misses++;
            $display("FAIL %s par_err_n actual=%b expected=%b", tag, par_err_n, e_err);
        end
        if (out_data !== e_out) begin
            misses++;
            $display("FAIL %s out_data actual=%h expected=%h", tag, out_data, e_out);
        end
    endtask

    initial begin
        logic [DW-1:0] good;
        void'($urandom(32'd7177));
        // Idle state: all-zero word passes even parity, nothing generated (R2, R5)
        #3;
        vectors++;
        if (par_err_n !== 1'b1 || out_data !== '0) begin
            misses++;
            $display("FAIL R5 idle actual=%b/%h expected=1/0", par_err_n, out_data);
        end
        // R1/R3: single bad lane at each lane position, write cycle
        for (int l = 0; l < LANES; l++) begin
            good = fix_lanes(1'b1, 36'h5A5A5A5A5);
            apply(1'b1, 1'b0, 1'b1, 1'b0, good, '0, "R3_all_pass");
            good[l*LANE_W + 8] = ~good[l*LANE_W + 8];
            apply(1'b1, 1'b0, 1'b1, 1'b0, good, '0, "R1_R3_lane_bad");
        end
        // R2: same word judged under both senses
        apply(1'b0, 1'b0, 1'b1, 1'b0, '0, '0, "R2_even_zero");
        apply(1'b1, 1'b0, 1'b1, 1'b0, '0, '0, "R2_odd_zero");
        apply(1'b1, 1'b0, 1'b1, 1'b0, {4{9'h100}}, '0, "R2_odd_tops");
        // R6: generating mailbox read with garbage pins
        apply(1'b1, 1'b1, 1'b0, 1'b1, '0, 36'h123456789, "R6_forced_odd");
        apply(1'b0, 1'b1, 1'b0, 1'b1, 36'hFFFFFFFF1, 36'hFEDCBA987, "R6_forced_even");
        // R7: near neighbours of the forcing case still check pins
        apply(1'b1, 1'b1, 1'b0, 1'b0, '0, 36'h0F0F0F0F0, "R7_queue_read_gen");
        apply(1'b1, 1'b1, 1'b1, 1'b1, '0, 36'h0F0F0F0F0, "R7_mbox_write");
        apply(1'b1, 1'b0, 1'b0, 1'b1, '0, 36'h0F0F0F0F0, "R7_mbox_read_nogen");
        // R4/R5: generation on and off with all-ones payload
        apply(1'b0, 1'b1, 1'b0, 1'b0, '0, {DW{1'b1}}, "R4_gen_even");
        apply(1'b1, 1'b1, 1'b0, 1'b1, '0, {DW{1'b1}}, "R4_gen_odd_mbox");
        apply(1'b1, 1'b0, 1'b0, 1'b0, '0, {DW{1'b1}}, "R5_passthrough");
        // R8 and all: random vectors, each settling within the same cycle
        for (int n = 0; n < 3000; n++) begin
            logic [63:0] a = {$urandom(), $urandom()};
            logic [63:0] b = {$urandom(), $urandom()};
            logic [3:0]  c = 4'($urandom());
            logic [DW-1:0] pins = a[DW-1:0];
            if (c[0]) pins = fix_lanes(c[1], pins);
            if (c[0] && ($urandom() % 2 == 0))
                pins[($urandom() % LANES) * LANE_W + ($urandom() % LANE_W)] ^= 1'b1;
            apply(c[1], c[2], c[3], 1'($urandom()), pins, b[DW-1:0], "R8_random");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    // Watchdog: a hung run counts as a miscompare
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule